// File: doc/BRIEF.md
# Nine-Bit Address Match Detector

This block sits on the receive side of a multi-drop serial link that uses 9-bit characters. The most significant bit of each character marks it as an address (1) or as data (0). When the receiver moves a character into its FIFO, the character is also offered to this block. The block then does three things:

- It records whether the ninth bit was set.
- It compares the full 9-bit value against four programmable match slots.
- It records whether the character carried any error status.

Each event is kept in a sticky flag until software reads the status register. Each flag can raise an interrupt request through its own enable. A small priority encoder reports the most urgent pending source:

- Error is level 1 and ranks first.
- Address-bit is level 2 and ranks next.
- Match is level 5 and ranks last.

The character input is a valid/ready stream. `chr_ready` is held high at all times, so the block never applies back-pressure. Every cycle in which `chr_valid` is high counts as exactly one character transferred into the FIFO. When `chr_valid` is low, the data and error inputs are ignored.

Top module: `nb_addr_match`

## Requirements
- R1: `chr_ready` is 1 in every cycle after reset. With `chr_valid` low, no flag is set, whatever `chr_data` and `chr_err` carry.
- R2: A character transferred with bit 8 = 1 sets `flag_addr` at the clock edge of its transfer. A character with bit 8 = 0 leaves `flag_addr` unchanged.
- R3: Slot i (pattern in `slot_pat[9*i+8:9*i]`) hits when all 9 bits of the transferred character equal its pattern. Bit 8 takes part in the compare. A hit sets `slot_hits[i]`, and `flag_match` is the OR of `slot_hits`.
- R4: A slot whose `slot_en[i]` is 0 never hits.
- R5: Several enabled slots with equal patterns all record a hit from the same character.
- R6: A transferred character with any nonzero bit in `chr_err` sets `flag_err`.
- R7: All flags hold until a cycle with `status_rd` high, which clears them at that edge. An event in the same cycle as the read leaves its flag set.
- R8: `irq_err`, `irq_addr` and `irq_match` equal their flag ANDed with `irq_en_err`, `irq_en_addr` and `irq_en_match`. Clearing an enable hides the request without clearing the flag.
- R9: `irq_code` is 01 for error, 10 for address and 11 for match, and 00 when none is pending. The ranking is error first, then address, then match.
- R10: Reset clears every flag and every interrupt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chr_valid | input | 1 | Character is being transferred into the receive FIFO this cycle |
| chr_ready | output | 1 | Always 1; the block never stalls |
| chr_data | input | 9 | Received character; bit 8 is the address bit |
| chr_err | input | 3 | Error status attached to the character |
| slot_pat | input | 36 | Four 9-bit match patterns; slot i occupies bits 9i+8..9i |
| slot_en | input | 4 | Per-slot match enable |
| irq_en_err | input | 1 | Enable for the error interrupt |
| irq_en_addr | input | 1 | Enable for the address-bit interrupt |
| irq_en_match | input | 1 | Enable for the match interrupt |
| status_rd | input | 1 | Status register read; clears the sticky flags |
| flag_err | output | 1 | Sticky error flag |
| flag_addr | output | 1 | Sticky address-bit flag |
| flag_match | output | 1 | OR of all slot hits |
| slot_hits | output | 4 | Sticky per-slot hit flags |
| irq_err | output | 1 | Level-1 error interrupt request |
| irq_addr | output | 1 | Address-bit interrupt request |
| irq_match | output | 1 | Level-5 match interrupt request |
| irq_code | output | 2 | Highest pending source |

## Verification
The bench sends a character that differs from an enabled pattern only in bit 8. A comparator that ignores the ninth bit would report a false hit there. It sends a matching value to a disabled slot, which catches a design that compares before gating. It sends a character in the same cycle as a status read, so a design that lets the clear win would lose the event. It also sends a character whose error, address and match conditions all apply at once. An encoder with the wrong ranking would report match or address instead of error. Enables are then dropped one by one, which would expose flags that are wrongly cleared or requests that ignore their enable.

// File: rtl/nb_pkg.sv
package nb_pkg;
  localparam int NB_CHR_W = 9;
  localparam int NB_SLOTS = 4;
  localparam int NB_ERR_W = 3;

  typedef enum logic [1:0] {
    IRQ_NONE  = 2'b00,
    IRQ_ERR   = 2'b01,
    IRQ_ADDR  = 2'b10,
    IRQ_MATCH = 2'b11
  } irq_code_e;
endpackage

// File: rtl/nb_slot_cmp.sv
module nb_slot_cmp #(
  parameter int CHR_W = nb_pkg::NB_CHR_W
) (
  input  logic [CHR_W-1:0] pat,
  input  logic             en,
  input  logic [CHR_W-1:0] data,
  output logic             hit
);
  // full-width compare: address bit included
  always_comb hit = en && (data == pat);
endmodule

// File: rtl/nb_sticky_flag.sv
module nb_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !clr) |=> q);
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);
  assert_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);
endmodule

// File: rtl/nb_irq_prio.sv
module nb_irq_prio (
  input  logic              req_err,
  input  logic              req_addr,
  input  logic              req_match,
  output nb_pkg::irq_code_e code
);
  import nb_pkg::*;
  always_comb begin
    if (req_err)        code = IRQ_ERR;
    else if (req_addr)  code = IRQ_ADDR;
    else if (req_match) code = IRQ_MATCH;
    else                code = IRQ_NONE;
  end
endmodule

// File: rtl/nb_addr_match.sv
module nb_addr_match #(
  parameter int CHR_W = nb_pkg::NB_CHR_W,
  parameter int SLOTS = nb_pkg::NB_SLOTS,
  parameter int ERR_W = nb_pkg::NB_ERR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   chr_valid,
  output logic                   chr_ready,
  input  logic [CHR_W-1:0]       chr_data,
  input  logic [ERR_W-1:0]       chr_err,
  input  logic [SLOTS*CHR_W-1:0] slot_pat,
  input  logic [SLOTS-1:0]       slot_en,
  input  logic                   irq_en_err,
  input  logic                   irq_en_addr,
  input  logic                   irq_en_match,
  input  logic                   status_rd,
  output logic                   flag_err,
  output logic                   flag_addr,
  output logic                   flag_match,
  output logic [SLOTS-1:0]       slot_hits,
  output logic                   irq_err,
  output logic                   irq_addr,
  output logic                   irq_match,
  output logic [1:0]             irq_code
);
  import nb_pkg::*;

  localparam int ADDR_BIT = CHR_W - 1;

  logic [SLOTS-1:0] cmp_hit;
  logic             ev_addr;
  logic             ev_err;
  irq_code_e        code_e;

  assign chr_ready = 1'b1;
  assign ev_addr   = chr_valid && chr_data[ADDR_BIT];
  assign ev_err    = chr_valid && (|chr_err);

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    nb_slot_cmp #(.CHR_W(CHR_W)) u_cmp (
      .pat  (slot_pat[i*CHR_W +: CHR_W]),
      .en   (slot_en[i]),
      .data (chr_data),
      .hit  (cmp_hit[i])
    );
    nb_sticky_flag u_hit (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (chr_valid && cmp_hit[i]),
      .clr   (status_rd),
      .q     (slot_hits[i])
    );
  end

  nb_sticky_flag u_addr (
    .clk (clk), .rst_n (rst_n), .set (ev_addr), .clr (status_rd), .q (flag_addr)
  );
  nb_sticky_flag u_err (
    .clk (clk), .rst_n (rst_n), .set (ev_err), .clr (status_rd), .q (flag_err)
  );

  assign flag_match = |slot_hits;
  assign irq_err    = flag_err   && irq_en_err;
  assign irq_addr   = flag_addr  && irq_en_addr;
  assign irq_match  = flag_match && irq_en_match;

  nb_irq_prio u_prio (
    .req_err   (irq_err),
    .req_addr  (irq_addr),
    .req_match (irq_match),
    .code      (code_e)
  );
  assign irq_code = code_e;

  assert_addr_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_addr) |-> $past(chr_valid && chr_data[ADDR_BIT]));
  assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_err) |-> $past(chr_valid && (|chr_err)));
  assert_no_disabled_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_valid && slot_en == '0 && !status_rd) |=> $stable(slot_hits));
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!chr_valid && !status_rd) |=> ($stable(slot_hits) && $stable(flag_addr) && $stable(flag_err)));
  assert_err_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_code != 2'b01) |-> !irq_err);
endmodule

// File: tb/nb_addr_match_bench.sv
module nb_addr_match_bench;
  localparam int CLK_P = 10;
  localparam int W = 9;
  localparam int S = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chr_valid = 1'b0;
  logic chr_ready;
  logic [W-1:0] chr_data = '0;
  logic [2:0] chr_err = '0;
  logic [S*W-1:0] slot_pat;
  logic [S-1:0] slot_en = '0;
  logic en_e = 1'b0, en_a = 1'b0, en_m = 1'b0;
  logic status_rd = 1'b0;
  logic flag_err, flag_addr, flag_match;
  logic [S-1:0] slot_hits;
  logic irq_err, irq_addr, irq_match;
  logic [1:0] irq_code;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [12:0] exp_q[$];
  string tag_q[$];

  // bench model state
  logic m_err = 0, m_addr = 0;
  logic [S-1:0] m_hits = '0;

  always #(CLK_P/2) clk = ~clk;

  // patterns: slot0=0x1A5 slot1=0x0A5 slot2=0x1A5 slot3=0x033
  assign slot_pat = {9'h033, 9'h1A5, 9'h0A5, 9'h1A5};

  nb_addr_match u_nb_addr_match (
    .clk(clk), .rst_n(rst_n), .chr_valid(chr_valid), .chr_ready(chr_ready),
    .chr_data(chr_data), .chr_err(chr_err), .slot_pat(slot_pat), .slot_en(slot_en),
    .irq_en_err(en_e), .irq_en_addr(en_a), .irq_en_match(en_m), .status_rd(status_rd),
    .flag_err(flag_err), .flag_addr(flag_addr), .flag_match(flag_match),
    .slot_hits(slot_hits), .irq_err(irq_err), .irq_addr(irq_addr),
    .irq_match(irq_match), .irq_code(irq_code)
  );

  function automatic logic [12:0] pack_exp();
    logic ie, ia, im;
    logic [1:0] c;
    ie = m_err && en_e;
    ia = m_addr && en_a;
    im = (|m_hits) && en_m;
    c = ie ? 2'b01 : ia ? 2'b10 : im ? 2'b11 : 2'b00;
    return {1'b1, m_err, m_addr, |m_hits, m_hits, ie, ia, im, c};
  endfunction

  function automatic logic [12:0] actual();
    return {chr_ready, flag_err, flag_addr, flag_match, slot_hits,
            irq_err, irq_addr, irq_match, irq_code};
  endfunction

  task automatic op(input logic v, input logic [W-1:0] d, input logic [2:0] e,
                    input logic rd, input logic [S-1:0] sen,
                    input logic ee, input logic ea, input logic em, input string tag);
    logic [S-1:0] hit;
    @(negedge clk);
    chr_valid = v; chr_data = d; chr_err = e; status_rd = rd;
    slot_en = sen; en_e = ee; en_a = ea; en_m = em;
    for (int i = 0; i < S; i++)
      hit[i] = v && sen[i] && (d == slot_pat[i*W +: W]);
    m_hits = hit | (rd ? '0 : m_hits);
    m_addr = (v && d[W-1]) || (m_addr && !rd);
    m_err  = (v && (|e)) || (m_err && !rd);
    exp_q.push_back(pack_exp());
    tag_q.push_back(tag);
  endtask

  // monitor: pops one expected vector per cycle, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_P/4);
    if (exp_q.size() > 0) begin
      logic [12:0] ex;
      string t;
      ex = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (actual() !== ex) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", t, actual(), ex);
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #(CLK_P/4);
    checks++; // R10 reset state
    if (actual() !== 13'h1000) begin
      fails++;
      $display("FAIL R10 actual=%h expected=%h", actual(), 13'h1000);
    end
    op(1, 9'h012, 0, 0, 4'b0111, 1, 1, 1, "R2 data char no address flag");
    op(1, 9'h101, 0, 0, 4'b0111, 1, 1, 1, "R2 address char sets flag");
    op(0, 9'h000, 0, 1, 4'b0111, 1, 1, 1, "R7 read clears");
    op(1, 9'h0A5, 0, 0, 4'b0111, 1, 1, 1, "R3 slot1 match");
    op(1, 9'h1A5, 0, 0, 4'b0111, 1, 1, 1, "R5 duplicate slots both hit");
    op(0, 9'h1A5, 3'b111, 0, 4'b0111, 1, 1, 1, "R1 invalid ignored, R7 held");
    op(1, 9'h033, 0, 1, 4'b0111, 1, 1, 1, "R4 disabled slot3, read clears");
    op(1, 9'h133, 0, 0, 4'b0111, 1, 1, 1, "R2 address no match");
    op(1, 9'h101, 0, 1, 4'b0111, 1, 1, 1, "R7 event wins over read");
    op(1, 9'h0A5, 3'b010, 0, 4'b0111, 1, 1, 1, "R6 R9 error ranks first");
    op(0, 9'h000, 0, 0, 4'b0111, 0, 1, 1, "R8 R9 error masked, address next");
    op(0, 9'h000, 0, 0, 4'b0111, 0, 0, 1, "R8 R9 match last");
    op(0, 9'h000, 0, 0, 4'b0111, 0, 0, 0, "R8 all masked flags kept");
    op(0, 9'h000, 0, 1, 4'b1111, 1, 1, 1, "R7 clear all");
    op(1, 9'h033, 0, 0, 4'b1111, 1, 1, 1, "R3 slot3 enabled hits");
    op(0, 9'h000, 0, 1, 4'b1111, 1, 1, 1, "R7 clear");
    op(1, 9'h133, 0, 0, 4'b1111, 1, 1, 1, "R3 bit8 mismatch no hit");
    op(1, 9'h1A5, 0, 0, 4'b0000, 1, 1, 1, "R4 all slots disabled");
    op(0, 9'h1A5, 3'b001, 0, 4'b1111, 1, 1, 1, "R1 R6 invalid error ignored");
    @(negedge clk);
    chr_valid = 0; status_rd = 0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule